// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block conditions the second source operand of a data-processing operation before it reaches the ALU. It takes a data word, a shift kind, a shift count and the current carry flag. From these it returns the conditioned word and a shifter carry. Logical operations use that carry to update the flags. The first source operand never passes through it.

The block is purely combinational and has no clock, no reset and no handshake. A pipeline stage around it registers the inputs and outputs. The stream-style valid/ready convention does not apply because there is no storage inside the block.

Five kinds are supported: logical left, logical right, arithmetic right, rotate right, and a 33-bit rotate right through carry by one place. An arithmetic left shift is the same as the logical left shift, so it uses that encoding. Counts are 0 to 31. Register-held counts above 31 and the immediate-rotate encoding belong elsewhere.

Top module: `opnd_shifter`

## Requirements
- R1: Kind 3'b000 (logical left) by n in 1..31 returns the data shifted toward the MSB with the n low bits zero. The carry is data bit 32-n.
- R2: Kind 3'b001 (logical right) by n in 1..31 returns the data shifted toward the LSB with the n high bits zero. The carry is data bit n-1.
- R3: Kind 3'b010 (arithmetic right) by n in 1..31 fills the n high bits with copies of data bit 31. The carry is data bit n-1.
- R4: Kind 3'b011 (rotate right) by n in 1..31 puts the bits leaving bit 0 back in at bit 31. The carry is data bit n-1, which is also result bit 31.
- R5: Kind 3'b100 (rotate through carry) returns {carry_i, data[31:1]} with carry data bit 0. The count has no effect.
- R6: For kinds 3'b000 to 3'b011, a count of 0 returns the data unchanged, and the carry out equals carry_i.
- R7: Kinds 3'b101, 3'b110 and 3'b111 return the data unchanged, and the carry out equals carry_i, whatever the count.
- R8: The outputs depend only on the present inputs, with no cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_val_i | input | 32 | Second source operand |
| kind_i | input | 3 | Shift kind code |
| amt_i | input | 5 | Shift count, 0 to 31 |
| carry_i | input | 1 | Current carry flag |
| res_o | output | 32 | Conditioned operand |
| carry_o | output | 1 | Shifter carry out |

## Verification
The immediate assertions are evaluated whenever an input changes. They check the following:
- zero fill at the vacated end for the logical shifts;
- sign copies for the arithmetic shift;
- the agreement of rotate carry with result bit 31;
- the carry and top bit of the rotate through carry;
- pass-through for a zero count and for unused kinds.

Exact result words, and which bit each count selects as carry, are shown only by the bench. The bench sweeps every kind code and every count against its own model. It uses corner patterns such as a lone sign bit, alternating bits and all ones, plus random words. The absence of latency is shown by comparing in the same cycle the inputs are applied.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [2:0] {
    SH_LSL = 3'd0,
    SH_LSR = 3'd1,
    SH_ASR = 3'd2,
    SH_ROR = 3'd3,
    SH_RRX = 3'd4
  } shift_kind_e;
endpackage

// File: rtl/bshift_left.sv
module bshift_left #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  d_i,
  input  logic [AW-1:0] n_i,
  input  logic          c_i,
  output logic [W-1:0]  d_o,
  output logic          c_o
);
  logic [W-1:0] dv [0:AW];
  logic         cv [0:AW];

  assign dv[0] = d_i;
  assign cv[0] = c_i;

  // One stage per count bit; stage s moves by 2**s places.
  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int K = 1 << s;
    assign dv[s+1] = n_i[s] ? {dv[s][W-K-1:0], {K{1'b0}}} : dv[s];
    assign cv[s+1] = n_i[s] ? dv[s][W-K] : cv[s];
  end

  assign d_o = dv[AW];
  assign c_o = cv[AW];

  // R1: a nonzero count always clears bit 0
  always_comb begin
    if (n_i != '0)
      a_r1_low_zero: assert (d_o[0] == 1'b0) else $error("R1 low bit not zero");
  end
endmodule

// File: rtl/bshift_right.sv
module bshift_right #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  d_i,
  input  logic [AW-1:0] n_i,
  input  logic          c_i,
  input  logic          arith_i,
  input  logic          rot_i,
  output logic [W-1:0]  d_o,
  output logic          c_o
);
  logic [W-1:0] dv [0:AW];
  logic         cv [0:AW];
  logic         sign_fill;

  assign sign_fill = arith_i & d_i[W-1];
  assign dv[0] = d_i;
  assign cv[0] = c_i;

  // Shared right stages: fill comes from the wrapped bits or from the sign/zero.
  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int K = 1 << s;
    logic [K-1:0] fill;
    assign fill    = rot_i ? dv[s][K-1:0] : {K{sign_fill}};
    assign dv[s+1] = n_i[s] ? {fill, dv[s][W-1:K]} : dv[s];
    assign cv[s+1] = n_i[s] ? dv[s][K-1] : cv[s];
  end

  assign d_o = dv[AW];
  assign c_o = cv[AW];

  always_comb begin
    if (n_i != '0 && !rot_i && !arith_i)
      a_r2_top_zero: assert (d_o[W-1] == 1'b0) else $error("R2 top bit not zero");
    if (n_i != '0 && !rot_i && arith_i)
      a_r3_sign_copy: assert (d_o[W-1] == d_i[W-1]) else $error("R3 sign not kept");
    if (n_i != '0 && rot_i)
      a_r4_rot_carry: assert (c_o == d_o[W-1]) else $error("R4 carry mismatch");
  end
endmodule

// File: rtl/bshift_rrx.sv
module bshift_rrx #(
  parameter int W = 32
) (
  input  logic [W-1:0] d_i,
  input  logic         c_i,
  output logic [W-1:0] d_o,
  output logic         c_o
);
  assign d_o = {c_i, d_i[W-1:1]};
  assign c_o = d_i[0];
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter #(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] op_val_i,
  input  logic [2:0]        kind_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  import bshift_pkg::*;

  logic [DATA_W-1:0] lft_d, rgt_d, rrx_d;
  logic              lft_c, rgt_c, rrx_c;
  logic              is_asr, is_ror;

  assign is_asr = (kind_i == SH_ASR);
  assign is_ror = (kind_i == SH_ROR);

  bshift_left #(.W(DATA_W), .AW(AMT_W)) u_left (
    .d_i(op_val_i), .n_i(amt_i), .c_i(carry_i), .d_o(lft_d), .c_o(lft_c)
  );

  bshift_right #(.W(DATA_W), .AW(AMT_W)) u_right (
    .d_i(op_val_i), .n_i(amt_i), .c_i(carry_i),
    .arith_i(is_asr), .rot_i(is_ror), .d_o(rgt_d), .c_o(rgt_c)
  );

  bshift_rrx #(.W(DATA_W)) u_rrx (
    .d_i(op_val_i), .c_i(carry_i), .d_o(rrx_d), .c_o(rrx_c)
  );

  always_comb begin
    unique case (kind_i)
      SH_LSL:                 begin res_o = lft_d;    carry_o = lft_c;   end
      SH_LSR, SH_ASR, SH_ROR: begin res_o = rgt_d;    carry_o = rgt_c;   end
      SH_RRX:                 begin res_o = rrx_d;    carry_o = rrx_c;   end
      default:                begin res_o = op_val_i; carry_o = carry_i; end
    endcase
  end

  always_comb begin
    if (kind_i <= 3'd3 && amt_i == '0)
      a_r6_zero_pass: assert (res_o == op_val_i && carry_o == carry_i)
        else $error("R6 zero count altered operand");
    if (kind_i == 3'd4)
      a_r5_rrx_carry: assert (carry_o == op_val_i[0] && res_o[DATA_W-1] == carry_i)
        else $error("R5 rotate-through-carry mismatch");
    if (kind_i >= 3'd5)
      a_r7_unused_pass: assert (res_o == op_val_i && carry_o == carry_i)
        else $error("R7 unused kind altered operand");
  end
endmodule

// File: tb/opnd_shifter_tb.sv
module opnd_shifter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_val;
  logic [2:0]  kind;
  logic [4:0]  amt;
  logic        cin;
  logic [31:0] res;
  logic        cout;
  int          n_chk = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  opnd_shifter dut_i (
    .op_val_i(op_val), .kind_i(kind), .amt_i(amt), .carry_i(cin),
    .res_o(res), .carry_o(cout)
  );

  // Behavioural model: result in [31:0], carry in [32]
  function automatic logic [32:0] model(input logic [2:0] k, input int n,
                                        input logic [31:0] v, input logic c);
    logic [63:0] w;
    if (k == 3'd4) return {v[0], c, v[31:1]};
    if (k > 3'd4 || n == 0) return {c, v};
    case (k)
      3'd0: return {v[32-n], v << n};
      3'd1: return {v[n-1], v >> n};
      3'd2: return {v[n-1], 32'($signed(v) >>> n)};
      default: begin
        w = {v, v} >> n;
        return {v[n-1], w[31:0]};
      end
    endcase
  endfunction

  function automatic string tag(input logic [2:0] k, input int n);
    if (k > 3'd4) return "R7";
    if (k == 3'd4) return "R5";
    if (n == 0) return "R6";
    case (k)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  // Inputs applied just after a rising edge, outputs sampled at the falling edge
  // of the same cycle (R8: no latency).
  task automatic apply(input logic [2:0] k, input int n, input logic [31:0] v, input logic c);
    logic [32:0] exp;
    @(posedge clk);
    #1;
    kind = k; amt = 5'(n); op_val = v; cin = c;
    exp = model(k, n, v, c);
    @(negedge clk);
    n_chk++;
    if ({cout, res} !== exp) begin
      n_fail++;
      $display("FAIL %s/R8 kind=%0d amt=%0d val=%h cin=%b: got res=%h c=%b exp res=%h c=%b",
               tag(k, n), k, n, v, c, res, cout, exp[31:0], exp[32]);
    end
  endtask

  initial begin
    logic [31:0] pats [8];
    pats = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0001,
             32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F96, 32'h5555_AAAA};
    op_val = '0; kind = '0; amt = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state: all-zero inputs give zero outputs
    @(negedge clk);
    n_chk++;
    if (res !== 32'h0 || cout !== 1'b0) begin
      n_fail++;
      $display("FAIL R6 idle: got res=%h c=%b exp res=0 c=0", res, cout);
    end
    // R1..R7 sweep over every kind, count and carry-in with corner patterns
    for (int k = 0; k < 8; k++)
      for (int n = 0; n < 32; n++)
        for (int p = 0; p < 8; p++)
          for (int c = 0; c < 2; c++)
            apply(3'(k), n, pats[p], c[0]);
    // random operands
    for (int i = 0; i < 1500; i++)
      apply(3'($urandom_range(0, 7)), $urandom_range(0, 31), $urandom, 1'($urandom));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule